// File: doc/BRIEF.md
# Raster Timing and Sync-Status Generator

This block runs on the pixel (dot) clock and walks a video raster. A pixel counter steps across each line. A line counter steps down the frame. An odd/even field flag follows interlaced scanning, and a frame counter counts completed retraces. Software sets the geometry and sync shape through four write-only-style registers: line geometry, sync shape, sync configuration and front porch. Each register can also be read back through a small read mux, with the bits that are not implemented returning zero.

The block gives a live status word that is derived combinationally from the current position. It carries the line number, the field flag and three sync and blanking indicators. The rule that forms these indicators changes with the relation between the line parity and the field flag. A one-cycle frame-start strobe marks the moment retrace ends.

Top module: `raster_sync_gen`

## Requirements
- R1: The geometry register (select 0) keeps the last-line index in bits 25:16 and the last-pixel index in bits 9:0. Writes are masked with 0x03FF03FF. A frame has last-line+1 lines of last-pixel+1 dot clocks.
- R2: After reset the geometry register reads 0x0270035F and the sync-shape register reads 0x0000053F. The sync-config and porch registers read 0. The pixel count, line count, field flag and frame count are all zero, and the status word is 0.
- R3: The pixel counter advances every cycle. On the last pixel it returns to 0 and the line counter advances, and the line counter returns to 0 after the last line. A write to the geometry register restarts both counters at 0 on the next cycle and leaves the field flag and the frame count unchanged.
- R4: Bit 4 of the sync-config register (select 2, write mask 0x3FF) enables interlace. With interlace enabled, the field flag inverts when the line counter wraps from the last line to 0, and at no other time. With interlace disabled, the field flag holds.
- R5: `frame_start` is high for exactly one cycle: the first cycle in which the line counter has advanced into line 42 (0x2A).
- R6: `frame_count` increments by one on the same edge that raises `frame_start` and changes at no other time.
- R7: Status bits 9:0 are the current line and bit 10 is the field flag (1 = odd). Bits 11, 12 and 13 mean display active, horizontal sync inactive and vertical sync inactive. Bits 31:14 are zero.
- R8: When bit 0 of the line equals the field flag, bit 12 is set while the pixel position exceeds the hsync width. The hsync width is (sync-shape bits 6:0 + 1) × 2. At or beyond the vsync line count (sync-shape bits 11:8), bit 13 is set, and bit 11 is added once the pixel position exceeds the front porch. The front porch is porch bits 9:0 + 1.
- R9: When bit 0 of the line differs from the field flag, then at or beyond the vsync line count bits 13 and 12 are set, and bit 11 is added while the pixel position plus the BACK_PORCH parameter is below the line length. Below the vsync line count, only bit 12 is set.
- R10: The sync-shape register (select 1) masks writes with 0x00000F7F and the porch register (select 3) masks writes with 0x3FF. Read select 4 returns the status word. Selects 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Combinational read data |
| status_word | output | 32 | Live sync-status word |
| frame_start | output | 1 | One-cycle retrace-end strobe |
| frame_count | output | FRAME_W | Frames since reset |

## Verification
A register write takes effect on the clock edge that samples it, so readback is checked at the following falling edge. A geometry write shows its counter restart as line 0 at that same falling edge. The status word and read data are combinational, so they are due in the same cycle as the position or select that drives them. `frame_start` and `frame_count` change on the edge that moves the line into 42. A reference model in the bench updates on the same edges as the design, and every falling edge compares status, strobe and count against it. Directed checks then cover reset, masking, interlace, field hold and restart.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam logic [31:0] GEOM_RESET  = 32'h0270_035F;
    localparam logic [31:0] SHAPE_RESET = 32'h07D6_A53F;
    localparam logic [31:0] GEOM_MASK   = 32'h03FF_03FF;
    localparam logic [31:0] SHAPE_MASK  = 32'h0000_0F7F;
    localparam logic [31:0] SCFG_MASK   = 32'h0000_03FF;
    localparam logic [31:0] PORCH_MASK  = 32'h0000_03FF;
    localparam logic [9:0]  RETRACE_END = 10'h02A;

    typedef enum logic [2:0] {
        SEL_GEOM   = 3'd0,
        SEL_SHAPE  = 3'd1,
        SEL_SCFG   = 3'd2,
        SEL_PORCH  = 3'd3,
        SEL_STATUS = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [9:0] last_line;
        logic [9:0] last_pix;
        logic [3:0] vsync_lines;
        logic [6:0] hsync_code;
        logic       interlace;
        logic [9:0] porch_code;
    } timing_cfg_t;

    typedef struct packed {
        logic [9:0] pix;
        logic [9:0] line;
        logic       field;
    } raster_pos_t;

    typedef struct packed {
        logic vsync_off;
        logic hsync_off;
        logic active;
    } sync_flags_t;

    function automatic logic [11:0] hsync_clocks(input logic [6:0] code);
        return ({5'd0, code} + 12'd1) << 1;
    endfunction

    function automatic logic [11:0] porch_clocks(input logic [9:0] code);
        return {2'd0, code} + 12'd1;
    endfunction

    function automatic logic [31:0] pack_status(input raster_pos_t p, input sync_flags_t f);
        return {18'd0, f.vsync_off, f.hsync_off, f.active, p.field, p.line};
    endfunction

endpackage

// File: rtl/raster_regs.sv
module raster_regs
    import raster_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] geom_q,
    output logic [31:0] shape_q,
    output logic [31:0] scfg_q,
    output logic [31:0] porch_q,
    output timing_cfg_t cfg,
    output logic        restart
);

    always_ff @(posedge clk) begin
        if (rst) begin
            geom_q  <= GEOM_RESET & GEOM_MASK;
            shape_q <= SHAPE_RESET & SHAPE_MASK;
            scfg_q  <= '0;
            porch_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_GEOM:  geom_q  <= wr_data & GEOM_MASK;
                SEL_SHAPE: shape_q <= wr_data & SHAPE_MASK;
                SEL_SCFG:  scfg_q  <= wr_data & SCFG_MASK;
                SEL_PORCH: porch_q <= wr_data & PORCH_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg.last_line   = geom_q[25:16];
        cfg.last_pix    = geom_q[9:0];
        cfg.vsync_lines = shape_q[11:8];
        cfg.hsync_code  = shape_q[6:0];
        cfg.interlace   = scfg_q[4];
        cfg.porch_code  = porch_q[9:0];
    end

    assign restart = wr_en && (wr_sel == SEL_GEOM);

endmodule

// File: rtl/raster_counter.sv
module raster_counter
    import raster_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  timing_cfg_t        cfg,
    input  logic               restart,
    output raster_pos_t        pos,
    output logic               frame_start,
    output logic [FRAME_W-1:0] frame_count
);

    logic end_of_line;
    logic end_of_frame;
    logic [9:0] line_inc;
    logic enter_retrace_end;

    assign end_of_line       = (pos.pix == cfg.last_pix);
    assign end_of_frame      = (pos.line == cfg.last_line);
    assign line_inc          = pos.line + 10'd1;
    assign enter_retrace_end = end_of_line && !end_of_frame && (line_inc == RETRACE_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos         <= '0;
            frame_start <= 1'b0;
            frame_count <= '0;
        end else if (restart) begin
            pos.pix     <= '0;
            pos.line    <= '0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= enter_retrace_end;
            if (enter_retrace_end) begin
                frame_count <= frame_count + 1'b1;
            end
            if (end_of_line) begin
                pos.pix <= '0;
                if (end_of_frame) begin
                    pos.line  <= '0;
                    pos.field <= pos.field ^ cfg.interlace;
                end else begin
                    pos.line <= line_inc;
                end
            end else begin
                pos.pix <= pos.pix + 10'd1;
            end
        end
    end

endmodule

// File: rtl/raster_status.sv
module raster_status
    import raster_pkg::*;
#(
    parameter int BACK_PORCH = 54
) (
    input  raster_pos_t  pos,
    input  timing_cfg_t  cfg,
    output logic [31:0]  status
);

    localparam logic [11:0] BP = 12'(BACK_PORCH);

    logic [11:0] pix_w;
    logic [11:0] line_len;
    logic        parity_match;
    logic        in_vsync;
    sync_flags_t flags;

    assign pix_w        = {2'd0, pos.pix};
    assign line_len     = {2'd0, cfg.last_pix} + 12'd1;
    assign parity_match = (pos.line[0] == pos.field);
    assign in_vsync     = (pos.line < {6'd0, cfg.vsync_lines});

    always_comb begin
        flags = '0;
        if (parity_match) begin
            flags.hsync_off = (pix_w > hsync_clocks(cfg.hsync_code));
            if (!in_vsync) begin
                flags.vsync_off = 1'b1;
                flags.active    = (pix_w > porch_clocks(cfg.porch_code));
            end
        end else begin
            flags.hsync_off = 1'b1;
            if (!in_vsync) begin
                flags.vsync_off = 1'b1;
                flags.active    = ((pix_w + BP) < line_len);
            end
        end
    end

    assign status = pack_status(pos, flags);

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
    import raster_pkg::*;
#(
    parameter int FRAME_W    = 16,
    parameter int BACK_PORCH = 54
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [31:0]        wr_data,
    input  logic [2:0]         rd_sel,
    output logic [31:0]        rd_data,
    output logic [31:0]        status_word,
    output logic               frame_start,
    output logic [FRAME_W-1:0] frame_count
);

    logic [31:0] geom_q, shape_q, scfg_q, porch_q;
    timing_cfg_t cfg;
    logic        restart;
    raster_pos_t pos;

    raster_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .geom_q  (geom_q),
        .shape_q (shape_q),
        .scfg_q  (scfg_q),
        .porch_q (porch_q),
        .cfg     (cfg),
        .restart (restart)
    );

    raster_counter #(.FRAME_W(FRAME_W)) u_counter (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .restart     (restart),
        .pos         (pos),
        .frame_start (frame_start),
        .frame_count (frame_count)
    );

    raster_status #(.BACK_PORCH(BACK_PORCH)) u_status (
        .pos    (pos),
        .cfg    (cfg),
        .status (status_word)
    );

    always_comb begin
        case (rd_sel)
            SEL_GEOM:   rd_data = geom_q;
            SEL_SHAPE:  rd_data = shape_q;
            SEL_SCFG:   rd_data = scfg_q;
            SEL_PORCH:  rd_data = porch_q;
            SEL_STATUS: rd_data = status_word;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/raster_sync_gen_chk.sv
module raster_sync_gen_chk #(
    parameter int FRAME_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [31:0]        status_word,
    input logic               frame_start,
    input logic [FRAME_W-1:0] frame_count
);

    a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    a_r5_strobe_on_line42: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (status_word[9:0] == 10'h02A));

    a_r6_count_steps: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (frame_count == $past(frame_count) + 1'b1));

    a_r6_count_holds: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> $stable(frame_count));

    a_r4_field_flips_at_line0: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_word[10]) |-> (status_word[9:0] == 10'd0));

    a_r3_line_steps: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_word[9:0]) |->
            ((status_word[9:0] == 10'd0) || (status_word[9:0] == $past(status_word[9:0]) + 10'd1)));

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        status_word[31:14] == 18'd0);

endmodule

bind raster_sync_gen raster_sync_gen_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .status_word (status_word),
    .frame_start (frame_start),
    .frame_count (frame_count)
);

// File: tb/raster_sync_gen_bench.sv
module raster_sync_gen_bench;

    localparam int FW = 16;
    localparam int BP = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [31:0] status_word;
    logic        frame_start;
    logic [FW-1:0] frame_count;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    raster_sync_gen #(.FRAME_W(FW), .BACK_PORCH(BP)) u_raster_sync_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .status_word(status_word),
        .frame_start(frame_start), .frame_count(frame_count)
    );

    // reference model
    logic [31:0] m_geom, m_shape, m_scfg, m_porch;
    int m_pix, m_line, m_frames;
    bit m_field, m_fs;

    always @(posedge clk) begin
        if (rst) begin
            m_geom = 32'h0270035F; m_shape = 32'h0000053F; m_scfg = 0; m_porch = 0;
            m_pix = 0; m_line = 0; m_field = 0; m_frames = 0; m_fs = 0;
        end else begin
            int len, nl;
            len = int'(m_geom[9:0]) + 1;
            nl  = int'(m_geom[25:16]) + 1;
            m_fs = 0;
            if (wr_en && wr_sel == 3'd0) begin
                m_pix = 0; m_line = 0;
            end else if (m_pix == len - 1) begin
                m_pix = 0;
                if (m_line == nl - 1) begin
                    m_line = 0;
                    if (m_scfg[4]) m_field = !m_field;
                end else begin
                    m_line = m_line + 1;
                    if (m_line == 42) begin m_fs = 1; m_frames = m_frames + 1; end
                end
            end else begin
                m_pix = m_pix + 1;
            end
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_geom  = wr_data & 32'h03FF03FF;
                    3'd1: m_shape = wr_data & 32'h00000F7F;
                    3'd2: m_scfg  = wr_data & 32'h3FF;
                    3'd3: m_porch = wr_data & 32'h3FF;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [2:0] exp_flags();
        int hsw, vsl, fpc, len;
        logic [2:0] f; // {vsync_off, hsync_off, active}
        hsw = (int'(m_shape[6:0]) + 1) * 2;
        vsl = int'(m_shape[11:8]);
        fpc = int'(m_porch[9:0]) + 1;
        len = int'(m_geom[9:0]) + 1;
        f = 3'b000;
        if ((m_line % 2) == int'(m_field)) begin
            if (m_pix > hsw) f[1] = 1;
            if (m_line >= vsl) begin f[2] = 1; if (m_pix > fpc) f[0] = 1; end
        end else begin
            f[1] = 1;
            if (m_line >= vsl) begin f[2] = 1; if (m_pix + BP < len) f[0] = 1; end
        end
        return f;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    int max_line = 0;
    int strobes = 0;
    always @(negedge clk) begin
        if (mon_on && !done) begin
            check("R7 line/field", {21'd0, status_word[10:0]}, {21'd0, m_field, 10'(m_line)});
            check("R7 upper zero", {14'd0, status_word[31:14]}, 32'd0);
            if ((m_line % 2) == int'(m_field))
                check("R8 sync bits", {29'd0, status_word[13:11]}, {29'd0, exp_flags()});
            else
                check("R9 sync bits", {29'd0, status_word[13:11]}, {29'd0, exp_flags()});
            check("R5 frame_start", {31'd0, frame_start}, {31'd0, m_fs});
            check("R6 frame_count", {16'd0, frame_count}, 32'(m_frames & 16'hFFFF));
            if (int'(status_word[9:0]) > max_line) max_line = int'(status_word[9:0]);
            if (frame_start) strobes++;
        end
    end

    task automatic write_reg(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic read_check(input string req, input logic [2:0] sel, input logic [31:0] exp);
        rd_sel = sel;
        #1;
        check(req, rd_data, exp);
    endtask

    // {write select, write data, expected readback}
    localparam logic [66:0] VEC [0:8] = '{
        {3'd0, 32'hFFFF_FFFF, 32'h03FF_03FF},
        {3'd1, 32'hFFFF_FFFF, 32'h0000_0F7F},
        {3'd2, 32'hFFFF_FFFF, 32'h0000_03FF},
        {3'd3, 32'hFFFF_FFFF, 32'h0000_03FF},
        {3'd5, 32'h1234_5678, 32'h0000_0000},
        {3'd0, 32'hFC2F_C013, 32'h002F_0013},
        {3'd1, 32'hABCD_B381, 32'h0000_0301},
        {3'd3, 32'hFFFF_FC05, 32'h0000_0005},
        {3'd2, 32'hFFFF_FC10, 32'h0000_0010}
    };

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state while reset is held
        check("R2 status", status_word, 32'd0);
        check("R2 frame_count", {16'd0, frame_count}, 32'd0);
        check("R2 frame_start", {31'd0, frame_start}, 32'd0);
        read_check("R2 geometry", 3'd0, 32'h0270035F);
        read_check("R2 sync shape", 3'd1, 32'h0000053F);
        read_check("R2 sync config", 3'd2, 32'd0);
        read_check("R2 porch", 3'd3, 32'd0);
        rst = 0;
        mon_on = 1;

        // R1 R10: masking and readback
        foreach (VEC[i]) begin
            write_reg(VEC[i][66:64], VEC[i][63:32]);
            if (VEC[i][66:64] == 3'd0)
                read_check("R1 geometry readback", 3'd0, VEC[i][31:0]);
            else
                read_check("R10 readback", VEC[i][66:64], VEC[i][31:0]);
        end
        read_check("R10 status via read mux", 3'd4, status_word);
        read_check("R10 select 7 reads zero", 3'd7, 32'd0);

        // R4: interlaced run over three frames (48 lines x 20 clocks)
        begin
            logic f0;
            f0 = status_word[10];
            repeat (960 * 3) @(negedge clk);
            check("R3 last line reached", 32'(max_line), 32'd47);
            check("R4 field toggled after odd frame count", {31'd0, status_word[10]}, {31'd0, m_field});
            check("R5 strobes seen", 32'(strobes), 32'(m_frames));
            check("R6 frames counted", {16'd0, frame_count}, 32'(m_frames));
            if (f0 == m_field) check("R4 field changed in interlace", 32'd0, 32'd1);
        end

        // R4: non-interlaced hold
        write_reg(3'd2, 32'h0);
        begin
            logic f1;
            f1 = status_word[10];
            repeat (2000) @(negedge clk);
            check("R4 field holds without interlace", {31'd0, status_word[10]}, {31'd0, f1});
        end

        // R3: restart on geometry write
        while (status_word[9:0] != 10'd10) @(negedge clk);
        begin
            logic [FW-1:0] fc;
            logic fl;
            fc = frame_count;
            fl = status_word[10];
            @(negedge clk);
            wr_en = 1; wr_sel = 3'd0; wr_data = 32'h002F_0013;
            @(negedge clk);
            wr_en = 0;
            check("R3 restart line zero", {22'd0, status_word[9:0]}, 32'd0);
            check("R3 restart keeps frame_count", {16'd0, frame_count}, {16'd0, fc});
            check("R3 restart keeps field", {31'd0, status_word[10]}, {31'd0, fl});
        end
        repeat (100) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule